// File: doc/BRIEF.md
# Region-of-Interest Readout Address Sequencer

This block walks a rectangular window of a pixel array (60 rows by 80 columns by default) and issues one address per clock during the readout stage of a depth-sensing frame. A start pulse captures the window limits and two mirror bits. A fixed preparation interval follows. The block then visits every row of the window. Each row gets a slot of clocks: the real column addresses come first, then any padding, then a single row-switch cycle.

A row slot is never shorter than half the array width plus one clock. A narrow window therefore reads out no faster than a half-width one. The readout length that results from the current register inputs is presented combinationally, so a frame timing sequencer can budget the readout stage before it issues the start pulse.

Mirroring is applied to rows and to columns independently. It reverses the order of visits and does not change the set of addresses that are visited. If a start limit lies above its end limit, the window collapses to the single row or column at the start limit.

Top module: `roi_scan_seq`

## Requirements
- R1: While reset is held and in the first cycle after its release, `frame_mark_o`, `row_mark_o`, `pix_valid_o` and `done_o` are 0, and both address outputs are 0.
- R2: A start pulse sampled at a clock edge while idle raises `frame_mark_o` in the next cycle (window cycle 0). Window cycles 0 to PREP-1 (0 to 99 by default) carry no valid pixel and no row marker.
- R3: Within each row slot, `pix_valid_o` is 1 on slot offsets 0 to ncols-1 and 0 on every later offset. Here ncols = col_hi-col_lo+1.
- R4: Every row slot lasts max(ncols, COLS/2)+1 clocks (41 clocks for any window of 40 or fewer columns by default). The last cycle of a slot is a row-switch cycle with no valid pixel.
- R5: With `flip_rows_i`=0, rows are visited from row_lo up to row_hi. With `flip_rows_i`=1, they are visited from row_hi down to row_lo. `row_addr_o` holds the row for the whole slot.
- R6: With `flip_cols_i`=0, the valid column addresses in a row run from col_lo upward. With `flip_cols_i`=1, they run from col_hi downward. `col_addr_o` is 0 whenever `pix_valid_o` is 0.
- R7: `row_mark_o` pulses for exactly one clock at slot offset 0 of each row, together with that row's first valid column.
- R8: `frame_mark_o` stays high for exactly `scan_len_o` consecutive cycles.
- R9: `done_o` is a single-cycle pulse in the first cycle after the window, which follows the switch cycle of the last row. `frame_mark_o` is 0 in that cycle.
- R10: `scan_len_o` equals PREP + nrows*(max(ncols, COLS/2)+1), computed combinationally from the current limit inputs.
- R11: A start limit greater than its end limit gives a single row (or column) at the start limit: the count is 1 and the address is the start value.
- R12: While `frame_mark_o` is high, a start pulse is ignored. Changes to the limit or mirror inputs during that time have no effect on the addresses or timing of the current readout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a readout (accepted while idle) |
| row_lo_i | input | 6 | First row limit of the window |
| row_hi_i | input | 6 | Last row limit of the window |
| col_lo_i | input | 7 | First column limit of the window |
| col_hi_i | input | 7 | Last column limit of the window |
| flip_rows_i | input | 1 | Reverse row visiting order |
| flip_cols_i | input | 1 | Reverse column order within a row |
| row_addr_o | output | 6 | Current row address |
| col_addr_o | output | 7 | Current column address, 0 when not valid |
| pix_valid_o | output | 1 | Cycle carries a real window column |
| row_mark_o | output | 1 | Row-boundary strobe |
| frame_mark_o | output | 1 | High across the whole readout window |
| done_o | output | 1 | One-cycle pulse after the window |
| scan_len_o | output | 13 | Readout length in clocks for the current inputs |

## Verification
The bench builds the sequencer with its default values: a 60 by 80 array and a 100-clock preparation interval. This makes the real half-width threshold reachable. Directed windows of exactly 40 and 41 columns sit on either side of the point where padding stops, and a full-array readout reaches the longest length of 4960 clocks. Random windows, including inverted limits and both mirror bits, are compared cycle by cycle against a bench model of the slot timing. One readout changes its inputs and pulses start while a readout is in progress.

// File: rtl/roi_seq_pkg.sv
package roi_seq_pkg;
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_PREP = 2'd1,
        PH_SCAN = 2'd2
    } phase_e;
endpackage

// File: rtl/roi_span.sv
// Number of indices covered by one axis of the window; inverted limits collapse to one.
module roi_span #(
    parameter int N = 60,
    localparam int AW = $clog2(N),
    localparam int CW = $clog2(N + 1)
) (
    input  logic [AW-1:0] lo_i,
    input  logic [AW-1:0] hi_i,
    output logic [CW-1:0] cnt_o
);
    always_comb begin
        if (hi_i >= lo_i) begin
            cnt_o = CW'(hi_i) - CW'(lo_i) + CW'(1);
        end else begin
            cnt_o = CW'(1);
        end
    end
endmodule

// File: rtl/roi_len_calc.sv
// Row slot length with the half-width floor, and total readout length.
module roi_len_calc #(
    parameter int ROWS = 60,
    parameter int COLS = 80,
    parameter int PREP = 100,
    localparam int RCW   = $clog2(ROWS + 1),
    localparam int CCW   = $clog2(COLS + 1),
    localparam int SLW   = $clog2(COLS + 2),
    localparam int LEN_W = $clog2(PREP + ROWS * (COLS + 1) + 1),
    localparam int HALF  = COLS / 2
) (
    input  logic [RCW-1:0]   nrows_i,
    input  logic [CCW-1:0]   ncols_i,
    output logic [SLW-1:0]   rowlen_o,
    output logic [LEN_W-1:0] total_o
);
    logic [SLW-1:0] body;

    always_comb begin
        if (ncols_i > CCW'(HALF)) begin
            body = SLW'(ncols_i);
        end else begin
            body = SLW'(HALF);
        end
        rowlen_o = body + SLW'(1);
        total_o  = LEN_W'(PREP) + LEN_W'(nrows_i) * LEN_W'(rowlen_o);
    end
endmodule

// File: rtl/roi_index_map.sv
// Converts a visit index into an address, reversing the order when flip is set.
module roi_index_map #(
    parameter int N  = 60,
    parameter int IW = 6,
    localparam int AW = $clog2(N),
    localparam int CW = $clog2(N + 1),
    localparam int EW = ((IW > CW) ? IW : CW) + 1
) (
    input  logic [AW-1:0] lo_i,
    input  logic [CW-1:0] cnt_i,
    input  logic [IW-1:0] idx_i,
    input  logic          flip_i,
    output logic [AW-1:0] addr_o
);
    logic [EW-1:0] sum;

    always_comb begin
        if (flip_i) begin
            sum = EW'(lo_i) + EW'(cnt_i) - EW'(1) - EW'(idx_i);
        end else begin
            sum = EW'(lo_i) + EW'(idx_i);
        end
        addr_o = sum[AW-1:0];
    end
endmodule

// File: rtl/roi_scan_seq.sv
module roi_scan_seq
    import roi_seq_pkg::*;
#(
    parameter int ROWS = 60,
    parameter int COLS = 80,
    parameter int PREP = 100,
    localparam int RAW   = $clog2(ROWS),
    localparam int CAW   = $clog2(COLS),
    localparam int LEN_W = $clog2(PREP + ROWS * (COLS + 1) + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [RAW-1:0]   row_lo_i,
    input  logic [RAW-1:0]   row_hi_i,
    input  logic [CAW-1:0]   col_lo_i,
    input  logic [CAW-1:0]   col_hi_i,
    input  logic             flip_rows_i,
    input  logic             flip_cols_i,
    output logic [RAW-1:0]   row_addr_o,
    output logic [CAW-1:0]   col_addr_o,
    output logic             pix_valid_o,
    output logic             row_mark_o,
    output logic             frame_mark_o,
    output logic             done_o,
    output logic [LEN_W-1:0] scan_len_o
);
    localparam int RCW = $clog2(ROWS + 1);
    localparam int CCW = $clog2(COLS + 1);
    localparam int SLW = $clog2(COLS + 2);
    localparam int PCW = $clog2(PREP + 1);

    typedef struct packed {
        phase_e         phase;
        logic [PCW-1:0] pcnt;
        logic [RCW-1:0] ridx;
        logic [SLW-1:0] slot;
        logic [RAW-1:0] rlo;
        logic [RCW-1:0] rcnt;
        logic [CAW-1:0] clo;
        logic [CCW-1:0] ccnt;
        logic [SLW-1:0] rowlen;
        logic           flipr;
        logic           flipc;
        logic           done;
    } seq_state_t;

    seq_state_t st_d, st_q;

    // Live window geometry from the register inputs
    logic [RCW-1:0]   live_nrows;
    logic [CCW-1:0]   live_ncols;
    logic [SLW-1:0]   live_rowlen;
    logic [LEN_W-1:0] live_total;

    roi_span #(.N(ROWS)) u_row_span (
        .lo_i (row_lo_i),
        .hi_i (row_hi_i),
        .cnt_o(live_nrows)
    );

    roi_span #(.N(COLS)) u_col_span (
        .lo_i (col_lo_i),
        .hi_i (col_hi_i),
        .cnt_o(live_ncols)
    );

    roi_len_calc #(.ROWS(ROWS), .COLS(COLS), .PREP(PREP)) u_len (
        .nrows_i (live_nrows),
        .ncols_i (live_ncols),
        .rowlen_o(live_rowlen),
        .total_o (live_total)
    );

    assign scan_len_o = live_total;

    // Address mapping from captured geometry
    logic [RAW-1:0] row_map;
    logic [CAW-1:0] col_map;

    roi_index_map #(.N(ROWS), .IW(RCW)) u_row_map (
        .lo_i  (st_q.rlo),
        .cnt_i (st_q.rcnt),
        .idx_i (st_q.ridx),
        .flip_i(st_q.flipr),
        .addr_o(row_map)
    );

    roi_index_map #(.N(COLS), .IW(SLW)) u_col_map (
        .lo_i  (st_q.clo),
        .cnt_i (st_q.ccnt),
        .idx_i (st_q.slot),
        .flip_i(st_q.flipc),
        .addr_o(col_map)
    );

    logic in_scan;
    logic slot_has_col;
    logic slot_last;
    logic row_last;

    always_comb begin
        in_scan      = (st_q.phase == PH_SCAN);
        slot_has_col = (st_q.slot < SLW'(st_q.ccnt));
        slot_last    = (st_q.slot == st_q.rowlen - SLW'(1));
        row_last     = (st_q.ridx == st_q.rcnt - RCW'(1));
    end

    // Next-state computation
    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        unique case (st_q.phase)
            PH_IDLE: begin
                if (start_i) begin
                    st_d.phase  = PH_PREP;
                    st_d.pcnt   = '0;
                    st_d.ridx   = '0;
                    st_d.slot   = '0;
                    st_d.rlo    = row_lo_i;
                    st_d.rcnt   = live_nrows;
                    st_d.clo    = col_lo_i;
                    st_d.ccnt   = live_ncols;
                    st_d.rowlen = live_rowlen;
                    st_d.flipr  = flip_rows_i;
                    st_d.flipc  = flip_cols_i;
                end
            end
            PH_PREP: begin
                if (st_q.pcnt == PCW'(PREP - 1)) begin
                    st_d.phase = PH_SCAN;
                    st_d.ridx  = '0;
                    st_d.slot  = '0;
                end else begin
                    st_d.pcnt = st_q.pcnt + PCW'(1);
                end
            end
            PH_SCAN: begin
                if (slot_last) begin
                    st_d.slot = '0;
                    if (row_last) begin
                        st_d.phase = PH_IDLE;
                        st_d.done  = 1'b1;
                    end else begin
                        st_d.ridx = st_q.ridx + RCW'(1);
                    end
                end else begin
                    st_d.slot = st_q.slot + SLW'(1);
                end
            end
            default: st_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{phase: PH_IDLE, default: '0};
        end else begin
            st_q <= st_d;
        end
    end

    // Outputs
    always_comb begin
        frame_mark_o = (st_q.phase != PH_IDLE);
        pix_valid_o  = in_scan && slot_has_col;
        row_mark_o   = in_scan && (st_q.slot == '0);
        row_addr_o   = in_scan ? row_map : '0;
        col_addr_o   = pix_valid_o ? col_map : '0;
        done_o       = st_q.done;
    end

    // Assertions
    p_valid_inside_frame_r3: assert property (@(posedge clk) disable iff (!rst_n)
        pix_valid_o |-> frame_mark_o)
        else $error("valid pixel outside readout window");

    p_row_mark_with_col_r7: assert property (@(posedge clk) disable iff (!rst_n)
        row_mark_o |-> pix_valid_o)
        else $error("row marker without first column");

    p_done_after_window_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!frame_mark_o && $past(frame_mark_o)))
        else $error("done not directly after window");

    p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o)
        else $error("done held longer than one cycle");

    p_col_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_valid_o && !row_mark_o && !st_q.flipc) |->
            (col_addr_o == $past(col_addr_o) + CAW'(1)))
        else $error("ascending column sequence broken");

    p_col_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
        pix_valid_o |-> (col_addr_o < CAW'(COLS)))
        else $error("column address out of array");

    p_row_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_scan && $past(in_scan) && !row_mark_o) |-> $stable(row_addr_o))
        else $error("row address changed inside a slot");

    p_geom_frozen_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_mark_o && $past(frame_mark_o)) |->
            ($stable(st_q.rowlen) && $stable(st_q.rcnt) && $stable(st_q.flipr)))
        else $error("captured geometry changed during readout");
endmodule

// File: tb/tb_roi_scan_seq.sv
module tb_roi_scan_seq;
    localparam int ROWS = 60;
    localparam int COLS = 80;
    localparam int PREP = 100;
    localparam int HALF = COLS / 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [5:0]  row_lo_i = '0;
    logic [5:0]  row_hi_i = '0;
    logic [6:0]  col_lo_i = '0;
    logic [6:0]  col_hi_i = '0;
    logic        flip_rows_i = 1'b0;
    logic        flip_cols_i = 1'b0;
    logic [5:0]  row_addr_o;
    logic [6:0]  col_addr_o;
    logic        pix_valid_o;
    logic        row_mark_o;
    logic        frame_mark_o;
    logic        done_o;
    logic [12:0] scan_len_o;

    int n_tests = 0;
    int n_fail  = 0;

    always #4 clk = ~clk;

    roi_scan_seq #(.ROWS(ROWS), .COLS(COLS), .PREP(PREP)) dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i),
        .row_lo_i(row_lo_i), .row_hi_i(row_hi_i),
        .col_lo_i(col_lo_i), .col_hi_i(col_hi_i),
        .flip_rows_i(flip_rows_i), .flip_cols_i(flip_cols_i),
        .row_addr_o(row_addr_o), .col_addr_o(col_addr_o),
        .pix_valid_o(pix_valid_o), .row_mark_o(row_mark_o),
        .frame_mark_o(frame_mark_o), .done_o(done_o),
        .scan_len_o(scan_len_o)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int span(input int lo, input int hi);
        return (hi >= lo) ? hi - lo + 1 : 1;   // R11
    endfunction

    function automatic int slot_len(input int nc);
        return ((nc > HALF) ? nc : HALF) + 1;   // R4
    endfunction

    // One readout, checked cycle by cycle against the slot model
    task automatic run_scan(input int rlo, input int rhi, input int clo, input int chi,
                            input bit fr, input bit fc, input bit disturb);
        int nr, nc, rl, len;
        nr  = span(rlo, rhi);
        nc  = span(clo, chi);
        rl  = slot_len(nc);
        len = PREP + nr * rl;
        @(negedge clk);
        row_lo_i = 6'(rlo); row_hi_i = 6'(rhi);
        col_lo_i = 7'(clo); col_hi_i = 7'(chi);
        flip_rows_i = fr;   flip_cols_i = fc;
        #1;
        check(int'(scan_len_o) == len, "R10 scan_len", int'(scan_len_o), len);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        for (int t = 0; t <= len; t++) begin
            bit e_frame, e_valid, e_mark, e_done;
            int e_row, e_col;
            e_frame = (t < len);
            e_done  = (t == len);
            e_valid = 1'b0; e_mark = 1'b0; e_row = 0; e_col = 0;
            if (t >= PREP && t < len) begin
                int s, r, o;
                s = t - PREP;
                r = s / rl;
                o = s % rl;
                e_mark  = (o == 0);
                e_valid = (o < nc);
                e_row   = fr ? rlo + nr - 1 - r : rlo + r;
                if (e_valid) e_col = fc ? clo + nc - 1 - o : clo + o;
            end
            check(frame_mark_o == e_frame, "R8 frame_mark", int'(frame_mark_o), int'(e_frame));
            check(done_o == e_done, "R9 done", int'(done_o), int'(e_done));
            check(pix_valid_o == e_valid, (t < PREP) ? "R2 prep valid" : "R3/R4 valid",
                  int'(pix_valid_o), int'(e_valid));
            check(row_mark_o == e_mark, "R7 row_mark", int'(row_mark_o), int'(e_mark));
            check(int'(row_addr_o) == e_row, "R5 row_addr", int'(row_addr_o), e_row);
            check(int'(col_addr_o) == e_col, "R6 col_addr", int'(col_addr_o), e_col);
            if (disturb && t == 5) begin
                // R12: new limits and a start pulse during the readout
                row_lo_i = 6'd7; row_hi_i = 6'd9; col_lo_i = 7'd3; col_hi_i = 7'd60;
                flip_rows_i = ~fr; flip_cols_i = ~fc;
                start_i = 1'b1;
            end
            if (disturb && t == 6) start_i = 1'b0;
            @(negedge clk);
        end
        // Idle after done: no restart happened
        check(frame_mark_o == 1'b0 && done_o == 1'b0, "R12 idle after readout",
              int'(frame_mark_o), 0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd20251));
        repeat (3) @(negedge clk);
        // R1 during reset
        check(frame_mark_o == 0 && pix_valid_o == 0 && row_mark_o == 0 && done_o == 0,
              "R1 reset flags", int'({frame_mark_o, pix_valid_o, row_mark_o, done_o}), 0);
        check(row_addr_o == 0 && col_addr_o == 0, "R1 reset addr",
              int'(row_addr_o) + int'(col_addr_o), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(frame_mark_o == 0 && done_o == 0, "R1 after release",
              int'({frame_mark_o, done_o}), 0);

        // Directed corners
        run_scan(0, 59, 0, 79, 1'b0, 1'b0, 1'b0);  // full array, longest length
        run_scan(4, 6, 10, 49, 1'b0, 1'b0, 1'b0);  // exactly half width R4
        run_scan(4, 6, 10, 50, 1'b0, 1'b1, 1'b0);  // one above half R4 R6
        run_scan(12, 12, 33, 33, 1'b1, 1'b1, 1'b0); // single pixel
        run_scan(20, 10, 70, 5, 1'b1, 1'b0, 1'b0);  // inverted limits R11
        run_scan(59, 59, 79, 79, 1'b0, 1'b0, 1'b0); // far corner
        run_scan(2, 8, 0, 79, 1'b1, 1'b1, 1'b1);    // disturbed readout R12
        run_scan(30, 35, 40, 41, 1'b0, 1'b1, 1'b0); // narrow window padded

        // Random windows
        for (int k = 0; k < 16; k++) begin
            int a, b, c, d;
            a = int'($urandom % ROWS);
            b = int'($urandom % ROWS);
            c = int'($urandom % COLS);
            d = int'($urandom % COLS);
            if (($urandom % 4) != 0 && b < a) begin
                int tmp; tmp = a; a = b; b = tmp;
            end
            if (b - a > 25) b = a + 25;
            run_scan(a, b, c, d, 1'($urandom), 1'($urandom), 1'b0);
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule